// File: doc/BRIEF.md
# DDS Serial Register Programmer

This block loads a direct-digital-synthesis device over a slow three-wire serial link made of a bit clock, a data line and a frame strobe that doubles as the device's update signal. A single start pulse captures a 32-bit tuning word, a reference-clock multiplier and a charge-pump current given in microamps. The block then writes two device registers in a fixed order. The first is a 24-bit control register that holds the packed multiplier, a VCO-gain bit that is always set, and a 2-bit pump-current code. The second is the 32-bit tuning-word register. The tuning word arrives already computed.

Every register write is one frame. The frame strobe rises first. An instruction byte follows, with a write flag and a 5-bit address, and then the register data. Both go out most significant bit first, and the frame strobe falls after the last bit. The data line is driven inverted because an inverting level converter sits between this block and the device. Each pin state is held for a parameterised number of system clock cycles, so the link stays slow enough for the series resistors at the device inputs.

Top module: `dds_prog_top`

## Requirements
- R1: While reset is asserted, and at any time the block is idle, `sclk_o`, `sdio_o`, `ioupd_o` and `busy_o` are all low.
- R2: When a start pulse is accepted, `ftw_i`, `mult_i` and `pump_ua_i` are captured. Later changes to these inputs have no effect on the sequence in progress.
- R3: `busy_o` rises in the cycle after an accepted start and falls in the same cycle as the second frame's strobe falls. A start pulse seen while `busy_o` is high is ignored.
- R4: Each frame sends an instruction byte and then the data, both most significant bit first. In the instruction byte, bit 7 is 0 (write), bits 6:5 are 0 and bits 4:0 hold the register address.
- R5: `sdio_o` carries the complement of the logical bit, so a logical 1 drives it low. It changes only while `sclk_o` is low.
- R6: Each bit uses three steps: data set with the clock low, clock high, clock low. Every step lasts `HALF_CYC` cycles. `sclk_o` is low whenever no frame is open.
- R7: A frame opens with one `HALF_CYC` step in which `ioupd_o` is high and `sclk_o` is low. `ioupd_o` falls only after the clock-low step of the frame's last bit. Between the two frames it stays low for one step.
- R8: The first frame writes address 0x01 with 24 data bits. The second frame writes address 0x04 with 32 data bits.
- R9: The control data is built as follows: bits 7:3 hold the multiplier, bit 2 is 1, bits 1:0 hold (pump_ua − 75)/25, and bits 23:8 are 0. For 75, 100, 125 and 150 µA the pump code is 0 to 3.
- R10: After an accepted start, the block holds all three link pins low for one `HALF_CYC` step before the first frame opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| ftw_i | input | 32 | Precomputed frequency tuning word |
| mult_i | input | 5 | Reference clock multiplier (4 to 20) |
| pump_ua_i | input | 8 | Charge-pump current in µA (75, 100, 125, 150) |
| busy_o | output | 1 | High while a programming sequence runs |
| sclk_o | output | 1 | Serial bit clock |
| sdio_o | output | 1 | Serial data, inverted |
| ioupd_o | output | 1 | Frame and update strobe |

## Verification
All four outputs are registered. The all-low step begins in the cycle after the edge that samples the start pulse. From then on, each pin state the bench predicts lasts exactly `HALF_CYC` cycles. The bench builds the whole expected pin sequence, cycle by cycle, at the moment it drives a start that the model says is accepted. The queue begins with one idle entry for the cycle before that edge. One entry is popped and compared at each falling clock edge, so every result is checked in the cycle it is due. A serial decoder in the bench also rebuilds each frame from the clock rising edges and checks its address, length and data when the strobe falls.

// File: rtl/dds_prog_pkg.sv
package dds_prog_pkg;

  localparam int MULT_W = 5;
  localparam int PUMP_W = 8;
  localparam int INSTR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_OPEN,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_CLOSE
  } step_e;

  // Write instruction: bit 7 clear, bits 6:5 clear, low five bits address
  function automatic logic [INSTR_W-1:0] wr_instr(input logic [4:0] addr);
    wr_instr = {3'b000, addr};
  endfunction

  // Pump current in uA mapped to a two-bit code, 75 uA steps of 25
  function automatic logic [1:0] pump_code(input logic [PUMP_W-1:0] ua);
    logic [PUMP_W-1:0] delta;
    delta = ua - PUMP_W'(75);
    pump_code = 2'(delta / PUMP_W'(25));
  endfunction

endpackage

// File: rtl/dds_ctrl_pack.sv
module dds_ctrl_pack
  import dds_prog_pkg::*;
#(
  parameter int CTRL_BITS = 24
) (
  input  logic [MULT_W-1:0]    mult_i,
  input  logic [PUMP_W-1:0]    pump_ua_i,
  output logic [CTRL_BITS-1:0] ctrl_o
);

  logic [7:0] low_byte;

  always_comb begin
    low_byte = {mult_i, 1'b1, pump_code(pump_ua_i)};
    ctrl_o   = CTRL_BITS'(low_byte);
  end

endmodule

// File: rtl/dds_settle.sv
module dds_settle #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);

  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? CNT_W'(HALF_CYC - 1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dds_frame_seq.sv
module dds_frame_seq
  import dds_prog_pkg::*;
#(
  parameter int         CTRL_BITS = 24,
  parameter int         FTW_BITS  = 32,
  parameter logic [4:0] CTRL_ADDR = 5'h01,
  parameter logic [4:0] FTW_ADDR  = 5'h04
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CTRL_BITS-1:0] ctrl_i,
  input  logic [FTW_BITS-1:0]  ftw_i,
  input  logic                 settle_done_i,
  output logic                 settle_load_o,
  output logic                 busy_o,
  output logic                 sclk_o,
  output logic                 sdio_o,
  output logic                 ioupd_o
);

  localparam int DATA_MAX = (CTRL_BITS > FTW_BITS) ? CTRL_BITS : FTW_BITS;
  localparam int FRAME_W  = INSTR_W + DATA_MAX;
  localparam int NB_W     = $clog2(FRAME_W + 1);

  step_e              state_q, state_d;
  logic               second_q, second_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [NB_W-1:0]    nbit_q, nbit_d;
  logic               busy_q, busy_d;
  logic               sclk_q, sclk_d;
  logic               sdio_q, sdio_d;
  logic               upd_q, upd_d;
  logic               accept, advance;
  logic [FRAME_W-1:0] ctrl_frame, ftw_frame;

  assign ctrl_frame = FRAME_W'({wr_instr(CTRL_ADDR), ctrl_i}) << (FRAME_W - INSTR_W - CTRL_BITS);
  assign ftw_frame  = FRAME_W'({wr_instr(FTW_ADDR), ftw_i}) << (FRAME_W - INSTR_W - FTW_BITS);

  assign accept        = (state_q == ST_IDLE) && start_i;
  assign advance       = (state_q != ST_IDLE) && settle_done_i;
  assign settle_load_o = accept || advance;

  always_comb begin
    state_d  = state_q;
    second_d = second_q;
    shreg_d  = shreg_q;
    nbit_d   = nbit_q;
    busy_d   = busy_q;
    sclk_d   = sclk_q;
    sdio_d   = sdio_q;
    upd_d    = upd_q;
    if (accept) begin
      state_d  = ST_INIT;
      second_d = 1'b0;
      busy_d   = 1'b1;
      sclk_d   = 1'b0;
      sdio_d   = 1'b0;
      upd_d    = 1'b0;
    end else if (advance) begin
      case (state_q)
        ST_INIT: begin
          state_d = ST_OPEN;
          shreg_d = ctrl_frame;
          nbit_d  = NB_W'(INSTR_W + CTRL_BITS);
          upd_d   = 1'b1;
        end
        ST_CLOSE: begin
          state_d  = ST_OPEN;
          second_d = 1'b1;
          shreg_d  = ftw_frame;
          nbit_d   = NB_W'(INSTR_W + FTW_BITS);
          upd_d    = 1'b1;
        end
        ST_OPEN: begin
          state_d = ST_SETUP;
          sdio_d  = ~shreg_q[FRAME_W-1];
        end
        ST_SETUP: begin
          state_d = ST_HIGH;
          sclk_d  = 1'b1;
        end
        ST_HIGH: begin
          state_d = ST_LOW;
          sclk_d  = 1'b0;
          shreg_d = shreg_q << 1;
          nbit_d  = nbit_q - NB_W'(1);
        end
        ST_LOW: begin
          if (nbit_q != '0) begin
            state_d = ST_SETUP;
            sdio_d  = ~shreg_q[FRAME_W-1];
          end else if (!second_q) begin
            state_d = ST_CLOSE;
            upd_d   = 1'b0;
          end else begin
            state_d = ST_IDLE;
            upd_d   = 1'b0;
            busy_d  = 1'b0;
            sdio_d  = 1'b0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      shreg_q  <= '0;
      nbit_q   <= '0;
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      sdio_q   <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      shreg_q  <= shreg_d;
      nbit_q   <= nbit_d;
      busy_q   <= busy_d;
      sclk_q   <= sclk_d;
      sdio_q   <= sdio_d;
      upd_q    <= upd_d;
    end
  end

  assign busy_o  = busy_q;
  assign sclk_o  = sclk_q;
  assign sdio_o  = sdio_q;
  assign ioupd_o = upd_q;

endmodule

// File: rtl/dds_prog_top.sv
module dds_prog_top
  import dds_prog_pkg::*;
#(
  parameter int         HALF_CYC   = 4,
  parameter int         CTRL_BYTES = 3,
  parameter int         FTW_BYTES  = 4,
  parameter logic [4:0] CTRL_ADDR  = 5'h01,
  parameter logic [4:0] FTW_ADDR   = 5'h04
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [FTW_BYTES*8-1:0] ftw_i,
  input  logic [MULT_W-1:0]      mult_i,
  input  logic [PUMP_W-1:0]      pump_ua_i,
  output logic                   busy_o,
  output logic                   sclk_o,
  output logic                   sdio_o,
  output logic                   ioupd_o
);

  localparam int CTRL_BITS = CTRL_BYTES * 8;
  localparam int FTW_BITS  = FTW_BYTES * 8;

  logic [FTW_BITS-1:0]  ftw_q;
  logic [MULT_W-1:0]    mult_q;
  logic [PUMP_W-1:0]    pump_q;
  logic [CTRL_BITS-1:0] ctrl_word;
  logic                 cap_en;
  logic                 settle_load, settle_done;

  assign cap_en = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q  <= '0;
      mult_q <= '0;
      pump_q <= '0;
    end else if (cap_en) begin
      ftw_q  <= ftw_i;
      mult_q <= mult_i;
      pump_q <= pump_ua_i;
    end
  end

  dds_ctrl_pack #(.CTRL_BITS(CTRL_BITS)) u_pack (
    .mult_i    (mult_q),
    .pump_ua_i (pump_q),
    .ctrl_o    (ctrl_word)
  );

  dds_settle #(.HALF_CYC(HALF_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (settle_load),
    .done_o (settle_done)
  );

  dds_frame_seq #(
    .CTRL_BITS (CTRL_BITS),
    .FTW_BITS  (FTW_BITS),
    .CTRL_ADDR (CTRL_ADDR),
    .FTW_ADDR  (FTW_ADDR)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .ctrl_i        (ctrl_word),
    .ftw_i         (ftw_q),
    .settle_done_i (settle_done),
    .settle_load_o (settle_load),
    .busy_o        (busy_o),
    .sclk_o        (sclk_o),
    .sdio_o        (sdio_o),
    .ioupd_o       (ioupd_o)
  );

endmodule

// File: rtl/dds_prog_chk.sv
module dds_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic sclk_o,
  input logic sdio_o,
  input logic ioupd_o
);

  // R1: idle means a quiet link
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdio_o && !ioupd_o));

  // R3: the strobe is only ever high inside a busy sequence
  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ioupd_o |-> busy_o);

  // R3: a sequence only begins after a start pulse
  p_busy_from_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R5: data does not move on a rising clock
  p_data_still_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdio_o));

  // R6: clock pulses only inside an open frame
  p_clk_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> ioupd_o);

  // R7: a frame opens with the clock low
  p_open_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ioupd_o) |-> !sclk_o);

  // R7: the strobe does not fall while the clock is high
  p_close_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ioupd_o) |-> (!sclk_o && !$past(sclk_o)));

endmodule

bind dds_prog_top dds_prog_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .sclk_o  (sclk_o),
  .sdio_o  (sdio_o),
  .ioupd_o (ioupd_o)
);

// File: tb/dds_prog_top_tb.sv
module dds_prog_top_tb;

  localparam int HALF = 4;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] ftw_i;
  logic [4:0]  mult_i;
  logic [7:0]  pump_ua_i;
  logic        busy_o, sclk_o, sdio_o, ioupd_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit cmp_on = 0;

  // expected pins per cycle: {busy, sclk, sdio, ioupd}
  logic [3:0]  pin_q[$];
  logic [63:0] fw_q[$];
  int          fn_q[$];

  // decoder state
  logic [63:0] dec_word;
  int          dec_n;
  logic        prev_sclk, prev_upd;

  dds_prog_top #(.HALF_CYC(HALF)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ftw_i     (ftw_i),
    .mult_i    (mult_i),
    .pump_ua_i (pump_ua_i),
    .busy_o    (busy_o),
    .sclk_o    (sclk_o),
    .sdio_o    (sdio_o),
    .ioupd_o   (ioupd_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic hold_step(input logic s, input logic d, input logic u);
    for (int k = 0; k < HALF; k++) pin_q.push_back({1'b1, s, d, u});
  endtask

  // Behavioural model of one whole programming sequence (R4..R10)
  task automatic build_seq(input logic [31:0] ftw, input int mult, input int pump);
    logic cur_d;
    int   ctrl;
    logic [63:0] word;
    int   nb;
    ctrl = ((mult * 8) & 'hF8) | 4 | (((pump - 75) / 25) & 3);
    pin_q.push_back(4'b0000);
    cur_d = 1'b0;
    hold_step(0, 0, 0);                       // R10
    for (int f = 0; f < 2; f++) begin
      if (f == 0) begin
        word = (64'h01 << 24) | 64'(ctrl & 'hFFFFFF);
        nb   = 32;
      end else begin
        word = (64'h04 << 32) | 64'(ftw);
        nb   = 40;
      end
      fw_q.push_back(word);
      fn_q.push_back(nb);
      hold_step(0, cur_d, 1);                 // R7 open
      for (int i = nb - 1; i >= 0; i--) begin
        cur_d = ~word[i];                     // R5
        hold_step(0, cur_d, 1);
        hold_step(1, cur_d, 1);
        hold_step(0, cur_d, 1);
      end
      if (f == 0) hold_step(0, cur_d, 0);
    end
  endtask

  task automatic issue(input logic [31:0] ftw, input logic [4:0] mult, input logic [7:0] pump);
    @(posedge clk); #2;
    ftw_i = ftw; mult_i = mult; pump_ua_i = pump; start_i = 1'b1;
    if (pin_q.size() == 0) build_seq(ftw, int'(mult), int'(pump));
    @(posedge clk); #2;
    start_i = 1'b0;
    // R2: scramble the inputs after capture
    ftw_i = ~ftw; mult_i = 5'd17; pump_ua_i = 8'd100;
  endtask

  task automatic wait_idle();
    while (pin_q.size() != 0) begin
      @(posedge clk); #2;
    end
  endtask

  // Per-cycle comparison against the model, plus frame decoding
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [3:0] exp_p;
      logic [3:0] act_p;
      exp_p = (pin_q.size() != 0) ? pin_q.pop_front() : 4'b0000;
      act_p = {busy_o, sclk_o, sdio_o, ioupd_o};
      checks++;
      if (act_p !== exp_p) begin
        errors++;
        if (act_p[3] !== exp_p[3]) $display("FAIL R3 busy: actual %b expected %b at %0t", act_p[3], exp_p[3], $time);
        else if (act_p[2] !== exp_p[2]) $display("FAIL R6 sclk: actual %b expected %b at %0t", act_p[2], exp_p[2], $time);
        else if (act_p[1] !== exp_p[1]) $display("FAIL R5 sdio: actual %b expected %b at %0t", act_p[1], exp_p[1], $time);
        else $display("FAIL R7 ioupd: actual %b expected %b at %0t", act_p[0], exp_p[0], $time);
      end
      if (ioupd_o && !prev_upd) begin
        dec_word = '0;
        dec_n = 0;
      end
      if (sclk_o && !prev_sclk) begin
        dec_word = {dec_word[62:0], ~sdio_o};
        dec_n++;
      end
      if (!ioupd_o && prev_upd) begin
        logic [63:0] ew;
        int en;
        ew = (fw_q.size() != 0) ? fw_q.pop_front() : 64'hX;
        en = (fn_q.size() != 0) ? fn_q.pop_front() : -1;
        checks++;
        // R4 R8 R9 R2: address, length, control packing and captured word
        if (dec_word !== ew || dec_n != en) begin
          errors++;
          $display("FAIL R4 R8 R9 R2 frame: actual %0d bits %h expected %0d bits %h",
                   dec_n, dec_word, en, ew);
        end
      end
      prev_sclk = sclk_o;
      prev_upd  = ioupd_o;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ftw_i = '0; mult_i = 5'd8; pump_ua_i = 8'd150;
    prev_sclk = 1'b0; prev_upd = 1'b0; dec_word = '0; dec_n = 0;
    repeat (3) @(posedge clk);
    #5;
    checks++;                                  // R1 reset state
    if ({busy_o, sclk_o, sdio_o, ioupd_o} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 0000", {busy_o, sclk_o, sdio_o, ioupd_o});
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (3) @(posedge clk);

    // defaults, then a start while busy must be ignored (R3)
    issue(32'h1234_5678, 5'd8, 8'd150);
    repeat (50) @(posedge clk);
    issue(32'hDEAD_BEEF, 5'd4, 8'd75);
    wait_idle();
    repeat (5) @(posedge clk);

    // lowest legal settings, all-ones word
    issue(32'hFFFF_FFFF, 5'd4, 8'd75);
    wait_idle();
    // highest multiplier, back to back with the end of the last sequence
    issue(32'h0000_0000, 5'd20, 8'd100);
    wait_idle();
    issue(32'hA5A5_0F0F, 5'd13, 8'd125);
    repeat (HALF * 3) @(posedge clk);
    issue(32'h1111_1111, 5'd5, 8'd150);       // R3 ignored mid-frame
    wait_idle();
    repeat (10) @(posedge clk);

    // R1: idle after everything
    #1;
    checks++;
    if ({busy_o, sclk_o, sdio_o, ioupd_o} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 idle: actual %b expected 0000", {busy_o, sclk_o, sdio_o, ioupd_o});
    end
    // all frames decoded (R8)
    checks++;
    if (fw_q.size() != 0) begin
      errors++;
      $display("FAIL R8 frames left: actual %0d expected 0", fw_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule